// File: doc/BRIEF.md
# External Interrupt Sense and Status Unit

This unit takes a group of asynchronous external interrupt pins and turns each one into a level-high request for a parent interrupt controller. Every pin is resynchronised to the core clock and then passed through a detector. The detector is programmable per pin: it can fire on a low level, a falling edge, a rising edge, or on either edge. A detected event sets that pin's status bit. The status bit then holds the pin's request line high until software clears it.

Software reaches the unit over a plain single-cycle register port. The port carries a byte offset, a write strobe, 32-bit write data and combinational read data. A status bit is cleared by writing a zero into its position, so bits written as one are untouched. The parent controller sees a steady level for as long as the status bit is set, even if the pin event itself was only a one-cycle edge.

Top module: `ext_irq_sense`

## Requirements
- R1: Each of the 8 pins passes through two synchroniser flops. A pin change sampled at clock edge k sets the status bit at edge k+2, so the request is visible after that edge.
- R2: The mode register sits at byte offset 0x14 and gives pin n the field at bits [2n+1:2n]. Code 0 means low level, 1 falling edge, 2 rising edge and 3 either edge. Bits above 15 read as zero, and a new mode applies from the cycle after the write.
- R3: In low-level mode the status bit is set on every cycle that the synchronised pin is low, including the cycle in which software clears it.
- R4: In falling-edge mode only a high-to-low transition of the synchronised pin sets the status bit.
- R5: In rising-edge mode only a low-to-high transition of the synchronised pin sets the status bit.
- R6: In both-edge mode any transition of the synchronised pin sets the status bit, and a steady pin sets nothing.
- R7: The status register at byte offset 0x10 holds bit n for pin n and reads back its value. Writing 0 to a bit clears it, writing 1 leaves it unchanged, and set bits otherwise stay set.
- R8: When an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: Request output n is active high and equals status bit n.
- R10: Reset clears every status bit and every mode field, and presets the synchroniser flops to 1. As a result, a pin held high through reset produces no event.
- R11: Reads from any offset other than 0x10 and 0x14 return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| irq_req_o | output | 8 | Level-high requests toward the parent controller |

## Verification
The assertions assume the register port is driven cleanly on the clock: the offset, strobe and data are stable across each rising edge, and a write lasts exactly one cycle. They also assume the pins are observed only through the synchroniser, so each detector property is written against the synchronised and previous samples rather than the raw pins. The bench keeps within this by changing every input only on the falling clock edge. Pin toggles come at random intervals, writes carry random data to both live offsets and to an unused one, and directed steps hit clear-during-level, write-one and same-cycle set-and-clear.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] irq_req_o
);
  localparam int MODE_W = 2 * NUM_PINS;
  localparam logic [1:0] SENSE_LOW  = 2'd0;
  localparam logic [1:0] SENSE_FALL = 2'd1;
  localparam logic [1:0] SENSE_RISE = 2'd2;
  localparam logic [1:0] SENSE_BOTH = 2'd3;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] sync_r;
  logic [NUM_PINS-1:0] sync_q, prev_q, evt, keep, stat_q;
  logic [MODE_W-1:0]   mode_q;
  logic stat_sel, mode_sel;

  assign stat_sel  = (bus_addr == STAT_OFS);
  assign mode_sel  = (bus_addr == MODE_OFS);
  assign sync_q    = sync_r[SYNC_STAGES-1];
  assign keep      = (bus_we && stat_sel) ? bus_wdata[NUM_PINS-1:0] : '1;
  assign irq_req_o = stat_q;
  assign bus_rdata = stat_sel ? DATA_W'(stat_q) :
                     mode_sel ? DATA_W'(mode_q) : '0;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_det
    always_comb begin
      unique case (mode_q[2*i +: 2])
        SENSE_LOW:  evt[i] = ~sync_q[i];
        SENSE_FALL: evt[i] = prev_q[i] & ~sync_q[i];
        SENSE_RISE: evt[i] = ~prev_q[i] & sync_q[i];
        SENSE_BOTH: evt[i] = prev_q[i] ^ sync_q[i];
        default:    evt[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_r <= '1;
      prev_q <= '1;
      mode_q <= '0;
      stat_q <= '0;
    end else begin
      sync_r[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_r[s] <= sync_r[s-1];
      prev_q <= sync_q;
      if (bus_we && mode_sel) mode_q <= bus_wdata[MODE_W-1:0];
      stat_q <= (stat_q & keep) | evt;
    end
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_PINS-1:0]   irq_req_o,
  input logic [NUM_PINS-1:0]   sync_q,
  input logic [NUM_PINS-1:0]   prev_q,
  input logic [2*NUM_PINS-1:0] mode_q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    a_r3_level_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'd0 && !sync_q[i]) |=> irq_req_o[i]);
    a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'd1 && !(prev_q[i] && !sync_q[i]) && !irq_req_o[i]) |=> !irq_req_o[i]);
    a_r5_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'd2 && !(!prev_q[i] && sync_q[i]) && !irq_req_o[i]) |=> !irq_req_o[i]);
    a_r6_both_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'd3 && prev_q[i] == sync_q[i] && !irq_req_o[i]) |=> !irq_req_o[i]);
    a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'd3 && prev_q[i] != sync_q[i]) |=> irq_req_o[i]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_o[i] && !(bus_we && bus_addr == STAT_OFS && !bus_wdata[i])) |=> irq_req_o[i]);
  end
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != STAT_OFS && bus_addr != MODE_OFS) |-> bus_rdata == '0);
  a_r9_status_reads_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_OFS) |-> bus_rdata[NUM_PINS-1:0] == irq_req_o);
endmodule

bind ext_irq_sense ext_irq_sense_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STAT_OFS(STAT_OFS), .MODE_OFS(MODE_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req_o(irq_req_o),
  .sync_q(sync_q), .prev_q(prev_q), .mode_q(mode_q)
);

// File: tb/ext_irq_sense_tb_top.sv
module ext_irq_sense_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = 8'hFF;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_req_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  ext_irq_sense dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req_o(irq_req_o)
  );

  always #10 clk = ~clk;

  logic [7:0]  h1, h2, h3, exp_stat;
  logic [15:0] exp_mode;

  function automatic logic [7:0] evt_f(logic [15:0] m, logic [7:0] prv, logic [7:0] cur);
    logic [7:0] e;
    for (int i = 0; i < 8; i++) begin
      case (m[2*i +: 2])
        2'd0: e[i] = !cur[i];
        2'd1: e[i] = prv[i] && !cur[i];
        2'd2: e[i] = !prv[i] && cur[i];
        default: e[i] = prv[i] != cur[i];
      endcase
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a == 8'h10) return {24'd0, exp_stat};
    if (a == 8'h14) return {16'd0, exp_mode};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= 8'hFF; h2 <= 8'hFF; h3 <= 8'hFF;
      exp_stat <= '0; exp_mode <= '0;
    end else begin
      h1 <= pin_i; h2 <= h1; h3 <= h2;
      if (bus_we && bus_addr == 8'h14) exp_mode <= bus_wdata[15:0];
      exp_stat <= (exp_stat & ((bus_we && bus_addr == 8'h10) ? bus_wdata[7:0] : 8'hFF))
                  | evt_f(exp_mode, h3, h2);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, then compare outputs with the model
  task automatic cyc_step(string tag, logic [7:0] pins, logic we, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    pin_i = pins; bus_we = we; bus_addr = a; bus_wdata = d;
    #2;
    chk({tag, " req"}, {24'd0, irq_req_o}, {24'd0, exp_stat});
    chk({tag, " rd"}, bus_rdata, exp_rd(a));
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) cyc_step(tag, pin_i, 1'b0, 8'h10, 32'd0);
  endtask

  initial begin
    logic [7:0] p;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    #2;
    chk("R10 reset req", {24'd0, irq_req_o}, 32'd0);
    bus_addr = 8'h14; #1;
    chk("R10 reset mode", bus_rdata, 32'd0);
    rst_n = 1'b1;
    idle("R10 high pins quiet", 4);
    chk("R10 no event", {24'd0, irq_req_o}, 32'd0);

    // R3 level low, clear while low re-sets
    cyc_step("R3", 8'hFB, 1'b0, 8'h10, 32'd0);
    idle("R1 latency", 2);
    chk("R1 not yet", {24'd0, irq_req_o}, 32'd0);
    idle("R1 latency", 1);
    chk("R1 set after two stages", {24'd0, irq_req_o}, 32'h04);
    cyc_step("R3 clear while low", pin_i, 1'b1, 8'h10, 32'hFB);
    idle("R3", 1);
    chk("R3 re-set after clear", {24'd0, irq_req_o}, 32'h04);
    cyc_step("R3 release", 8'hFF, 1'b0, 8'h10, 32'd0);
    idle("R3", 3);
    cyc_step("R7 clear", pin_i, 1'b1, 8'h10, 32'hFB);
    idle("R7", 1);
    chk("R7 cleared", {24'd0, irq_req_o}, 32'd0);

    // modes: p0 fall, p1 rise, p2 both, p3 rise
    cyc_step("R2 mode wr", pin_i, 1'b1, 8'h14, 32'hFFFF_00B9);
    idle("R2", 1);
    chk("R2 mode read masks upper", bus_rdata & 32'hFFFF_0000, 32'd0);
    bus_addr = 8'h14; #1;
    chk("R2 mode readback", bus_rdata, 32'h0000_00B9);
    bus_addr = 8'h10;
    // p3 is rising (code 2) only in the low byte? 0xB9 => p0=1,p1=2,p2=3,p3=2
    cyc_step("R4 fall", 8'hF0, 1'b0, 8'h10, 32'd0);
    idle("R4", 3);
    chk("R4 fall p0, both p2 set; rise p1,p3 not", {24'd0, irq_req_o}, 32'h05);
    cyc_step("R7 write ones", pin_i, 1'b1, 8'h10, 32'hFF);
    idle("R7", 1);
    chk("R7 ones no effect", {24'd0, irq_req_o}, 32'h05);
    cyc_step("R7 clr all", pin_i, 1'b1, 8'h10, 32'h00);
    cyc_step("R5 rise", 8'hFF, 1'b0, 8'h10, 32'd0);
    idle("R5", 3);
    chk("R5 rise p1,p3 and both p2", {24'd0, irq_req_o}, 32'h0E);
    cyc_step("R6 clr", pin_i, 1'b1, 8'h10, 32'h00);
    idle("R6 steady", 4);
    chk("R6 steady no event", {24'd0, irq_req_o}, 32'h00);

    // R8: clear lands in the same cycle as the p2 edge reaches the detector
    cyc_step("R8", 8'hFB, 1'b0, 8'h10, 32'd0);
    cyc_step("R8", pin_i, 1'b0, 8'h10, 32'd0);
    cyc_step("R8 clear on event", pin_i, 1'b1, 8'h10, 32'h00);
    idle("R8", 1);
    chk("R8 event wins", {24'd0, irq_req_o}, 32'h04);

    // R11 unmapped offset
    cyc_step("R11 write", pin_i, 1'b1, 8'h18, 32'h0);
    idle("R11", 1);
    chk("R11 status kept", {24'd0, irq_req_o}, 32'h04);
    bus_addr = 8'h18; #1;
    chk("R11 reads zero", bus_rdata, 32'd0);

    // random phase
    p = pin_i;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic w;
      logic [31:0] d;
      if ($urandom_range(7) == 0) p[$urandom_range(7)] ^= 1'b1;
      case ($urandom_range(3))
        0: a = 8'h10;
        1: a = 8'h14;
        2: a = 8'h18;
        default: a = 8'h00;
      endcase
      w = ($urandom_range(9) == 0);
      d = $urandom;
      if (w && a == 8'h14 && $urandom_range(1) == 0) d = d | 32'h5555;
      cyc_step("R9 random", p, w, a, d);
    end
    finish_run();
  end
endmodule